// File: doc/BRIEF.md
# Streaming Vector Register Execution Unit

This block keeps a bank of vector registers and runs one whole-register operation at a time through a short pipeline. Each operation handles one element position per clock. Two operations, add and subtract, write a destination vector element by element. The other two reduce the source data to a single scalar value. Compare builds a bit mask with one bit per element. Accumulate sums every element of one register.

A host loads register elements through a write port and reads them back through a combinational read port. It issues an instruction by raising a valid strobe while the unit is idle. The unit then reports `busy` for a fixed number of cycles and pulses `done` when the scalar result becomes valid. Memory traffic, chaining and floating point are handled elsewhere.

Top module: `vu_top`

## Requirements
- R1: After reset `busy`, `done` and `scalar` are all 0.
- R2: Opcode 0 (add) writes VRd[i] = VRa[i] + VRb[i] modulo 2^64 for every index i from 0 to 63.
- R3: Opcode 1 (subtract) writes VRd[i] = VRa[i] - VRb[i] modulo 2^64 for every i.
- R4: Opcode 2 (compare) sets `scalar` bit i to 1 exactly when VRa[i] < VRb[i] as signed 64-bit integers. It writes no register.
- R5: Opcode 3 (accumulate) sets `scalar` to the sum of all 64 elements of VRa modulo 2^64. The `instr_rb` input is ignored and no register is written.
- R6: An instruction is accepted on a clock edge where `instr_valid` is high and `busy` is low. `busy` is then high for exactly 66 cycles. `done` is high for one cycle, on the cycle `busy` falls, and `scalar` changes only on that cycle. Add and subtract give `scalar` = 0.
- R7: `instr_valid` is ignored while `busy` is high. The refused instruction changes no register and does not extend the operation in progress.
- R8: When the unit is idle, a host write (`wr_en`) stores `wr_data` at element `wr_idx` of register `wr_reg`, and `rd_data` shows element `rd_idx` of register `rd_reg` in the same cycle. Host writes made while `busy` is high are ignored.
- R9: When the destination register is also a source, every element is computed from the old values of the sources. For example, VR1 <- VR1 + VR1 doubles each element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_op | input | 2 | Opcode: 0 add, 1 sub, 2 compare, 3 accumulate |
| instr_ra | input | 3 | First source register |
| instr_rb | input | 3 | Second source register |
| instr_rd | input | 3 | Destination register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| scalar | output | 64 | Scalar result (mask or sum) |
| wr_en | input | 1 | Host element write enable |
| wr_reg | input | 3 | Host write register |
| wr_idx | input | 6 | Host write element index |
| wr_data | input | 64 | Host write data |
| rd_reg | input | 3 | Host read register |
| rd_idx | input | 6 | Host read element index |
| rd_data | output | 64 | Host read data (combinational) |

## Verification
The element counter is the single piece of state behind everything else, so an error in it shows up at the ports. A bad value moves the fall of `busy` and the `done` pulse away from cycle 66. It also leaves some destination elements unwritten or written at the wrong index, which the read port exposes as soon as the operation ends. A wrong operand latch or a mis-timed write-back corrupts the aliased case at once, because a second read of an element that was already overwritten gives a value that differs from the doubled original. Mask and sum errors show up on `scalar` at the `done` pulse. The state of a refused instruction or an ignored host write stays visible in the register bank until the bench reads it back.

// File: rtl/vu_pkg.sv
package vu_pkg;
    localparam int unsigned NREG_DEF = 8;
    localparam int unsigned VLEN_DEF = 64;
    localparam int unsigned EW_DEF   = 64;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_CMP = 2'd2,
        OP_ACC = 2'd3
    } vop_e;
endpackage

// File: rtl/vu_regfile.sv
// Flat vector register storage: two operand read ports, one host read port,
// one write port. NREG and VLEN are powers of two.
module vu_regfile #(
    parameter int unsigned NREG = vu_pkg::NREG_DEF,
    parameter int unsigned VLEN = vu_pkg::VLEN_DEF,
    parameter int unsigned EW   = vu_pkg::EW_DEF,
    localparam int unsigned RW  = $clog2(NREG),
    localparam int unsigned IW  = $clog2(VLEN),
    localparam int unsigned DEPTH = NREG * VLEN
) (
    input  logic          clk,
    input  logic [RW-1:0] a_reg,
    input  logic [IW-1:0] a_idx,
    output logic [EW-1:0] a_data,
    input  logic [RW-1:0] b_reg,
    input  logic [IW-1:0] b_idx,
    output logic [EW-1:0] b_data,
    input  logic [RW-1:0] h_reg,
    input  logic [IW-1:0] h_idx,
    output logic [EW-1:0] h_data,
    input  logic          we,
    input  logic [RW-1:0] w_reg,
    input  logic [IW-1:0] w_idx,
    input  logic [EW-1:0] w_data
);
    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{w_reg, w_idx}] <= w_data;
        end
    end

    assign a_data = mem[{a_reg, a_idx}];
    assign b_data = mem[{b_reg, b_idx}];
    assign h_data = mem[{h_reg, h_idx}];
endmodule

// File: rtl/vu_alu.sv
// Element function: wrapping add/sub and signed less-than.
module vu_alu #(
    parameter int unsigned EW = vu_pkg::EW_DEF
) (
    input  vu_pkg::vop_e  op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] elem,
    output logic          lt
);
    always_comb begin
        elem = (op == vu_pkg::OP_SUB) ? (a - b) : (a + b);
        lt   = $signed(a) < $signed(b);
    end
endmodule

// File: rtl/vu_ctrl.sv
// Sequencer: element issue counter, operand stage, write-back and reductions.
module vu_ctrl #(
    parameter int unsigned NREG = vu_pkg::NREG_DEF,
    parameter int unsigned VLEN = vu_pkg::VLEN_DEF,
    parameter int unsigned EW   = vu_pkg::EW_DEF,
    localparam int unsigned RW  = $clog2(NREG),
    localparam int unsigned IW  = $clog2(VLEN),
    localparam int unsigned CW  = $clog2(VLEN + 3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_i,
    input  logic [RW-1:0] ra_i,
    input  logic [RW-1:0] rb_i,
    input  logic [RW-1:0] rd_i,
    output logic [RW-1:0] a_reg,
    output logic [RW-1:0] b_reg,
    output logic [IW-1:0] rd_idx,
    input  logic [EW-1:0] a_data,
    input  logic [EW-1:0] b_data,
    output logic          wb_we,
    output logic [RW-1:0] wb_reg,
    output logic [IW-1:0] wb_idx,
    output logic [EW-1:0] wb_data,
    output logic          busy,
    output logic          done,
    output logic [EW-1:0] scalar
);
    localparam logic [CW-1:0] ISSUE_END = CW'(VLEN);
    localparam logic [CW-1:0] LAST_CNT  = CW'(VLEN + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        vu_pkg::vop_e  op;
        logic [RW-1:0] ra;
        logic [RW-1:0] rb;
        logic [RW-1:0] rd;
        logic          s1_v;
        logic [IW-1:0] s1_idx;
        logic [EW-1:0] s1_a;
        logic [EW-1:0] s1_b;
        logic [EW-1:0] acc;
        logic [VLEN-1:0] mask;
        logic [EW-1:0] scalar;
    } st_t;

    st_t q, d;
    logic [EW-1:0] alu_elem;
    logic          alu_lt;

    vu_alu #(.EW(EW)) u_alu (
        .op  (q.op),
        .a   (q.s1_a),
        .b   (q.s1_b),
        .elem(alu_elem),
        .lt  (alu_lt)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.s1_v = 1'b0;

        a_reg  = q.ra;
        b_reg  = q.rb;
        rd_idx = q.cnt[IW-1:0];

        // stage 2: write-back or reduction of the element held in stage 1
        wb_we   = q.s1_v && (q.op == vu_pkg::OP_ADD || q.op == vu_pkg::OP_SUB);
        wb_reg  = q.rd;
        wb_idx  = q.s1_idx;
        wb_data = alu_elem;
        if (q.s1_v && q.op == vu_pkg::OP_CMP) begin
            d.mask[q.s1_idx] = alu_lt;
        end
        if (q.s1_v && q.op == vu_pkg::OP_ACC) begin
            d.acc = q.acc + q.s1_a;
        end

        if (q.busy) begin
            // stage 1: capture operands of the element being issued
            d.cnt    = q.cnt + 1'b1;
            d.s1_v   = q.cnt < ISSUE_END;
            d.s1_idx = q.cnt[IW-1:0];
            d.s1_a   = a_data;
            d.s1_b   = b_data;
            if (q.cnt == LAST_CNT) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                unique case (q.op)
                    vu_pkg::OP_CMP: d.scalar = EW'(q.mask);
                    vu_pkg::OP_ACC: d.scalar = q.acc;
                    default:        d.scalar = '0;
                endcase
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.op   = vu_pkg::vop_e'(op_i);
            d.ra   = ra_i;
            d.rb   = rb_i;
            d.rd   = rd_i;
            d.acc  = '0;
            d.mask = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy   = q.busy;
    assign done   = q.done;
    assign scalar = q.scalar;
endmodule

// File: rtl/vu_top.sv
module vu_top #(
    parameter int unsigned NREG = vu_pkg::NREG_DEF,
    parameter int unsigned VLEN = vu_pkg::VLEN_DEF,
    parameter int unsigned EW   = vu_pkg::EW_DEF,
    localparam int unsigned RW  = $clog2(NREG),
    localparam int unsigned IW  = $clog2(VLEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [1:0]    instr_op,
    input  logic [RW-1:0] instr_ra,
    input  logic [RW-1:0] instr_rb,
    input  logic [RW-1:0] instr_rd,
    output logic          busy,
    output logic          done,
    output logic [EW-1:0] scalar,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_reg,
    input  logic [IW-1:0] wr_idx,
    input  logic [EW-1:0] wr_data,
    input  logic [RW-1:0] rd_reg,
    input  logic [IW-1:0] rd_idx,
    output logic [EW-1:0] rd_data
);
    logic [RW-1:0] a_reg, b_reg, wb_reg;
    logic [IW-1:0] op_idx, wb_idx;
    logic [EW-1:0] a_data, b_data, wb_data;
    logic          wb_we, host_we, start;
    logic          rf_we;
    logic [RW-1:0] rf_wreg;
    logic [IW-1:0] rf_widx;
    logic [EW-1:0] rf_wdata;

    assign start   = instr_valid && !busy;
    assign host_we = wr_en && !busy;

    always_comb begin
        rf_we    = wb_we || host_we;
        rf_wreg  = wb_we ? wb_reg  : wr_reg;
        rf_widx  = wb_we ? wb_idx  : wr_idx;
        rf_wdata = wb_we ? wb_data : wr_data;
    end

    vu_ctrl #(.NREG(NREG), .VLEN(VLEN), .EW(EW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_i   (instr_op),
        .ra_i   (instr_ra),
        .rb_i   (instr_rb),
        .rd_i   (instr_rd),
        .a_reg  (a_reg),
        .b_reg  (b_reg),
        .rd_idx (op_idx),
        .a_data (a_data),
        .b_data (b_data),
        .wb_we  (wb_we),
        .wb_reg (wb_reg),
        .wb_idx (wb_idx),
        .wb_data(wb_data),
        .busy   (busy),
        .done   (done),
        .scalar (scalar)
    );

    vu_regfile #(.NREG(NREG), .VLEN(VLEN), .EW(EW)) u_rf (
        .clk   (clk),
        .a_reg (a_reg),
        .a_idx (op_idx),
        .a_data(a_data),
        .b_reg (b_reg),
        .b_idx (op_idx),
        .b_data(b_data),
        .h_reg (rd_reg),
        .h_idx (rd_idx),
        .h_data(rd_data),
        .we    (rf_we),
        .w_reg (rf_wreg),
        .w_idx (rf_widx),
        .w_data(rf_wdata)
    );
endmodule

// File: rtl/vu_checks.sv
module vu_checks #(
    parameter int unsigned VLEN = vu_pkg::VLEN_DEF,
    parameter int unsigned EW   = vu_pkg::EW_DEF,
    localparam int unsigned CW  = $clog2(VLEN + 3)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          instr_valid,
    input logic [EW-1:0] scalar,
    input logic          host_we
);
    logic [CW-1:0] busy_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_cnt_q <= '0;
        end else begin
            busy_cnt_q <= busy_cnt_q + 1'b1;
        end
    end

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt_q == CW'(VLEN + 2));
    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt_q < CW'(VLEN + 2));
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_scalar_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(scalar));
    assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_valid));
    assert_host_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_we);
endmodule

bind vu_top vu_checks #(.VLEN(VLEN), .EW(EW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .instr_valid(instr_valid),
    .scalar     (scalar),
    .host_we    (host_we)
);

// File: tb/vu_top_tb.sv
`timescale 1ns/1ps
module vu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [1:0]  instr_op = '0;
    logic [2:0]  instr_ra = '0, instr_rb = '0, instr_rd = '0;
    logic        busy, done;
    logic [63:0] scalar;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_reg = '0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_reg = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model [8][64];

    always #2 clk = ~clk;

    vu_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_ra(instr_ra), .instr_rb(instr_rb), .instr_rd(instr_rd),
        .busy(busy), .done(done), .scalar(scalar),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [63:0] exp_mask(input int a, input int b);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) m[i] = $signed(model[a][i]) < $signed(model[b][i]);
        return m;
    endfunction

    function automatic logic [63:0] exp_sum(input int a);
        logic [63:0] s = '0;
        for (int i = 0; i < 64; i++) s = s + model[a][i];
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic hwrite(input int r, input int i, input logic [63:0] v);
        wr_en = 1'b1; wr_reg = 3'(r); wr_idx = 6'(i); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_reg(input int r, input bit rnd, input logic [63:0] v);
        for (int i = 0; i < 64; i++) begin
            model[r][i] = rnd ? {$urandom, $urandom} : v;
            hwrite(r, i, model[r][i]);
        end
    endtask

    task automatic check_reg(input int r, input string req);
        bit ok = 1'b1;
        logic [63:0] a = '0, e = '0;
        for (int i = 0; i < 64; i++) begin
            rd_reg = 3'(r); rd_idx = 6'(i);
            #0.5;
            if (ok && rd_data !== model[r][i]) begin
                ok = 1'b0; a = rd_data; e = model[r][i];
            end
        end
        check(ok, req, $sformatf("register %0d contents", r), a, e);
    endtask

    // Issues one instruction; optional injection of a refused instruction
    // (R7) and an ignored host write (R8) while busy.
    task automatic run(input int op, input int a, input int b, input int d,
                       input int refuse_rd, input int wr_reg_ign);
        int n = 0;
        logic [63:0] tmp [64];
        logic [63:0] exp_s;
        string req;
        req = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
        exp_s = (op == 2) ? exp_mask(a, b) : (op == 3) ? exp_sum(a) : 64'd0;
        for (int i = 0; i < 64; i++)
            tmp[i] = (op == 1) ? model[a][i] - model[b][i] : model[a][i] + model[b][i];
        instr_valid = 1'b1; instr_op = 2'(op);
        instr_ra = 3'(a); instr_rb = 3'(b); instr_rd = 3'(d);
        @(negedge clk);
        instr_valid = 1'b0;
        while (busy && n < 200) begin
            n++;
            if (n == 10 && refuse_rd >= 0) begin
                instr_valid = 1'b1; instr_op = 2'd0;
                instr_ra = 3'(a); instr_rb = 3'(a); instr_rd = 3'(refuse_rd);
            end
            if (n == 20 && wr_reg_ign >= 0) begin
                wr_en = 1'b1; wr_reg = 3'(wr_reg_ign); wr_idx = 6'd5;
                wr_data = ~model[wr_reg_ign][5];
            end
            @(negedge clk);
            instr_valid = 1'b0;
            wr_en = 1'b0;
        end
        check(n == 66, "R6", "busy cycle count", 64'(n), 64'd66);
        check(done === 1'b1, "R6", "done at busy fall", 64'(done), 64'd1);
        check(scalar === exp_s, req, "scalar result", scalar, exp_s);
        if (op < 2) for (int i = 0; i < 64; i++) model[d][i] = tmp[i];
        check_reg(d, req);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R6", "done single pulse",
              {62'd0, busy, done}, 64'd0);
        check(scalar === exp_s, "R6", "scalar held", scalar, exp_s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R6 watchdog expired actual=hang expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0 && scalar === 64'd0, "R1", "reset outputs",
              {62'd0, busy, done} | scalar, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 loads visible on the read port
        for (int r = 0; r < 8; r++) load_reg(r, 1'b1, '0);
        for (int r = 0; r < 8; r++) check_reg(r, "R8");

        // R2 / R3 directed
        run(0, 0, 1, 2, -1, -1);
        run(1, 3, 4, 5, -1, -1);

        // R4 directed signed edges
        for (int i = 0; i < 64; i++) begin
            model[6][i] = 64'(i - 32);
            model[7][i] = (i % 4 == 0) ? model[6][i] :
                          (i % 4 == 1) ? 64'(31 - i) : {$urandom, $urandom};
            hwrite(6, i, model[6][i]);
            hwrite(7, i, model[7][i]);
        end
        model[6][63] = 64'h8000_0000_0000_0000; hwrite(6, 63, model[6][63]);
        model[7][63] = 64'h7FFF_FFFF_FFFF_FFFF; hwrite(7, 63, model[7][63]);
        run(2, 6, 7, 6, -1, -1);
        run(2, 7, 6, 0, -1, -1);

        // R5 wrap-around sum
        load_reg(5, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        run(3, 5, 0, 5, -1, -1);
        check(scalar === 64'hFFFF_FFFF_FFFF_FFC0, "R5", "all-ones wrap sum",
              scalar, 64'hFFFF_FFFF_FFFF_FFC0);

        // R9 destination aliases both sources
        run(0, 1, 1, 1, -1, -1);

        // R7 refused instruction, R8 ignored host write while busy
        run(1, 2, 3, 4, 7, 0);
        check_reg(7, "R7");
        check_reg(0, "R8");

        // random mix
        for (int k = 0; k < 24; k++)
            run(int'($urandom % 4), int'($urandom % 8), int'($urandom % 8),
                int'($urandom % 8), -1, -1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule